// File: doc/BRIEF.md
# RTC Alarm Comparator with Interrupt

This block watches the running time of a real-time clock and raises a sticky alarm flag when the time equals a programmed alarm setting. The time arrives as packed-BCD registers: hundredths of a second, seconds, minutes, hours, day of the week, and date of the month. A one-cycle update tick marks each new time value. The comparison is made only on that tick, so one matching time value sets the flag once.

The alarm settings are loaded through a small write port that has a register select. One alarm register serves for both day and date. Its select bit decides whether the stored value is compared with the day of the week or with the date of the month. The sub-second alarm register normally holds a BCD value from 00 to 99. Some reserved codes in it relax the comparison: they either ignore the tenths digit or ignore the sub-second field entirely.

The interrupt pin is active low. It is asserted while the flag, an interrupt-enable bit and an interrupt-mode bit are all set. Software clears the flag with a strobe. If a clear and a new match arrive in the same cycle, the match wins.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarmFlag` is 0, `intN` is 1, and all alarm and control registers are 0.
- R2: When `tick` is 1 and every enabled field matches, `alarmFlag` is 1 from the next clock edge. The matched fields are sub-seconds (`wrSel`=0), seconds (1), minutes (2), hours (3) and day/date (4). Each field is compared bit for bit.
- R3: `alarmFlag` is not set when `tick` is 0, or when any enabled field differs from its alarm value.
- R4: When bit 6 of the day/date alarm register is 0, its bits 5..0 are compared with `curDate`, and `curDow` has no effect.
- R5: When bit 6 of the day/date alarm register is 1, its bits 5..0 are compared with `curDow`, and `curDate` has no effect.
- R6: A sub-second alarm code from 0xF0 to 0xF9 compares only its low nibble with the low (hundredths) nibble of `curHsec`. The tenths digit is ignored.
- R7: The sub-second alarm code 0xFF ignores `curHsec` entirely.
- R8: `alarmFlag` stays 1 until a cycle with `afClr` = 1, and is 0 after that edge when no match occurs in the same cycle.
- R9: When a tick match and `afClr` fall in the same cycle, `alarmFlag` is 1 after that edge.
- R10: `intN` is 0 exactly when `alarmFlag`, the interrupt-enable bit and the interrupt-mode bit are all 1. The interrupt-enable bit is bit 0 and the interrupt-mode bit is bit 1 of the control register (`wrSel`=5). In every other case `intN` is 1.
- R11: Writes with `wrSel` equal to 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per time update |
| curHsec | input | 8 | Current hundredths of seconds, BCD |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours register |
| curDow | input | 6 | Current day of week |
| curDate | input | 6 | Current date of month, BCD |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 3 | Register select for writes |
| wrData | input | 8 | Write data |
| afClr | input | 1 | Alarm-flag clear strobe |
| alarmFlag | output | 1 | Sticky alarm flag |
| intN | output | 1 | Interrupt output, active low |

## Verification
A matching tick and the flag-clear strobe can land on the same clock edge. The bench forces this by driving `afClr` and `tick` in the same cycle while the time equals the alarm. It then expects `alarmFlag` to be 1 after that edge. The bench also runs the opposite case: a clear with a tick whose time does not match must leave the flag at 0. The sub-second masking codes and the day/date select are swept over every legal time value. The expected flag for each value is computed arithmetically in the bench.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int DATA_W    = 8;
  localparam int DD_W      = 6;
  localparam int DAYSEL_BIT = 6;

  typedef enum logic [2:0] {
    SEL_HSEC    = 3'd0,
    SEL_SEC     = 3'd1,
    SEL_MIN     = 3'd2,
    SEL_HOUR    = 3'd3,
    SEL_DAYDATE = 3'd4,
    SEL_CTRL    = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrHsec;
    logic wrSec;
    logic wrMin;
    logic wrHour;
    logic wrDayDate;
    logic wrCtrl;
  } wrStrobes_t;
endpackage

// File: rtl/rtc_alarm_subsec_cmp.sv
module rtc_alarm_subsec_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] almCode,
  input  logic [DATA_W-1:0] curVal,
  output logic              hit
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0] MASK_NIB = '1;
  localparam logic [NIB_W-1:0] MAX_DIGIT = NIB_W'(9);

  logic [NIB_W-1:0] almHi, almLo, curLo;
  logic             ignoreAll, unitsOnly;

  assign almHi = almCode[DATA_W-1:NIB_W];
  assign almLo = almCode[NIB_W-1:0];
  assign curLo = curVal[NIB_W-1:0];

  always_comb begin
    ignoreAll = (almHi == MASK_NIB) && (almLo == MASK_NIB);
    unitsOnly = (almHi == MASK_NIB) && (almLo <= MAX_DIGIT);
    if (ignoreAll)      hit = 1'b1;
    else if (unitsOnly) hit = (almLo == curLo);
    else                hit = (almCode == curVal);
  end
endmodule

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int DDW = DD_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobes_t      strb,
  input  logic [W-1:0]    wrData,
  input  logic [W-1:0]    curHsec,
  input  logic [W-1:0]    curSec,
  input  logic [W-1:0]    curMin,
  input  logic [W-1:0]    curHour,
  input  logic [DDW-1:0]  curDow,
  input  logic [DDW-1:0]  curDate,
  output logic            timeMatch,
  output logic            irqEnable,
  output logic            irqMode
);
  logic [W-1:0]   almHsec, almSec, almMin, almHour;
  logic [DDW-1:0] almDdVal;
  logic           almDaySel;
  logic           hsecHit, ddHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almHsec   <= '0;
      almSec    <= '0;
      almMin    <= '0;
      almHour   <= '0;
      almDdVal  <= '0;
      almDaySel <= 1'b0;
      irqEnable <= 1'b0;
      irqMode   <= 1'b0;
    end else begin
      if (strb.wrHsec) almHsec <= wrData;
      if (strb.wrSec)  almSec  <= wrData;
      if (strb.wrMin)  almMin  <= wrData;
      if (strb.wrHour) almHour <= wrData;
      if (strb.wrDayDate) begin
        almDdVal  <= wrData[DDW-1:0];
        almDaySel <= wrData[DAYSEL_BIT];
      end
      if (strb.wrCtrl) begin
        irqEnable <= wrData[0];
        irqMode   <= wrData[1];
      end
    end
  end

  rtc_alarm_subsec_cmp #(.DATA_W(W)) u_subsec (
    .almCode (almHsec),
    .curVal  (curHsec),
    .hit     (hsecHit)
  );

  always_comb begin
    ddHit     = almDaySel ? (almDdVal == curDow) : (almDdVal == curDate);
    timeMatch = hsecHit && ddHit && (almSec == curSec) &&
                (almMin == curMin) && (almHour == curHour);
  end

  p_ff_ignores_hsec_r7: assert property (@(posedge clk) disable iff (!rstN)
    (almHsec == 8'hFF) |-> hsecHit);

  p_day_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (almDaySel && timeMatch) |-> (almDdVal == curDow));

  p_date_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!almDaySel && timeMatch) |-> (almDdVal == curDate));
endmodule

// File: rtl/rtc_alarm_control.sv
module rtc_alarm_control
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       afClr,
  input  logic       timeMatch,
  input  logic       irqEnable,
  input  logic       irqMode,
  output wrStrobes_t strb,
  output logic       alarmFlag,
  output logic       intN
);
  logic setFlag;

  always_comb begin
    strb           = '0;
    strb.wrHsec    = wrEn && (wrSel == SEL_HSEC);
    strb.wrSec     = wrEn && (wrSel == SEL_SEC);
    strb.wrMin     = wrEn && (wrSel == SEL_MIN);
    strb.wrHour    = wrEn && (wrSel == SEL_HOUR);
    strb.wrDayDate = wrEn && (wrSel == SEL_DAYDATE);
    strb.wrCtrl    = wrEn && (wrSel == SEL_CTRL);
  end

  assign setFlag = tick && timeMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        alarmFlag <= 1'b0;
    else if (setFlag) alarmFlag <= 1'b1;
    else if (afClr)   alarmFlag <= 1'b0;
  end

  assign intN = !(alarmFlag && irqEnable && irqMode);

  p_set_on_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && timeMatch) |=> alarmFlag);

  p_no_set_without_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && !tick) |=> !alarmFlag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !afClr) |=> alarmFlag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (afClr && !(tick && timeMatch)) |=> !alarmFlag);

  p_match_beats_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (afClr && tick && timeMatch) |=> alarmFlag);

  p_int_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqMode || !alarmFlag) |-> intN);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DATA_W-1:0] curHsec,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DD_W-1:0]   curDow,
  input  logic [DD_W-1:0]   curDate,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              afClr,
  output logic              alarmFlag,
  output logic              intN
);
  wrStrobes_t strb;
  logic       timeMatch, irqEnable, irqMode;

  rtc_alarm_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .afClr     (afClr),
    .timeMatch (timeMatch),
    .irqEnable (irqEnable),
    .irqMode   (irqMode),
    .strb      (strb),
    .alarmFlag (alarmFlag),
    .intN      (intN)
  );

  rtc_alarm_datapath #(.W(DATA_W), .DDW(DD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .curHsec   (curHsec),
    .curSec    (curSec),
    .curMin    (curMin),
    .curHour   (curHour),
    .curDow    (curDow),
    .curDate   (curDate),
    .timeMatch (timeMatch),
    .irqEnable (irqEnable),
    .irqMode   (irqMode)
  );
endmodule

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] curHsec = '0, curSec = '0, curMin = '0, curHour = '0;
  logic [5:0] curDow = '0, curDate = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       afClr = 1'b0;
  logic       alarmFlag, intN;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match dut (.*);

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit hsecExpect(input logic [7:0] code, input int v);
    if (code == 8'hFF) return 1'b1;
    if (code[7:4] == 4'hF && code[3:0] <= 4'd9) return (v % 10) == int'(code[3:0]);
    return code == toBcd(v);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); afClr = 1'b1;
    @(negedge clk); afClr = 1'b0;
  endtask

  task automatic baseTime();
    curSec = 8'h12; curMin = 8'h34; curHour = 8'h05; curDow = 6'd3; curDate = 6'h17;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    baseTime();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flag", alarmFlag, 1'b0);
    check("R1 intN", intN, 1'b1);
    rstN = 1'b1;
    // R1: alarm regs zero -> date 00 never matches a real date
    curHsec = 8'h00; curSec = 8'h00; curMin = 8'h00; curHour = 8'h00;
    pulseTick();
    check("R1 regs zero", alarmFlag, 1'b0);

    baseTime();
    wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h05); wr(3'd4, 8'h17);

    // R2 R6 R7: sweep sub-second codes over every hundredths value
    foreach (curHsec[i]) ; // no-op keeps style simple
    begin
      logic [7:0] codes [5] = '{8'h37, 8'hF4, 8'hF0, 8'hFF, 8'h99};
      for (int c = 0; c < 5; c++) begin
        wr(3'd0, codes[c]);
        for (int v = 0; v < 100; v++) begin
          clearFlag();
          curHsec = toBcd(v);
          pulseTick();
          check(codes[c] == 8'hFF ? "R7 ff mask" :
                (codes[c][7:4] == 4'hF ? "R6 tenths mask" : "R2 full hsec"),
                alarmFlag, hsecExpect(codes[c], v));
        end
      end
    end

    // R3: single-field mismatch and missing tick
    wr(3'd0, 8'hFF);
    clearFlag(); curSec = 8'h13; pulseTick(); check("R3 sec differs", alarmFlag, 1'b0);
    baseTime(); curMin = 8'h35; pulseTick(); check("R3 min differs", alarmFlag, 1'b0);
    baseTime(); curHour = 8'h06; pulseTick(); check("R3 hour differs", alarmFlag, 1'b0);
    baseTime(); repeat (3) @(negedge clk); check("R3 no tick", alarmFlag, 1'b0);

    // R4: date mode, sweep dates, then sweep day of week
    for (int d = 1; d <= 31; d++) begin
      clearFlag(); curDate = toBcd(d)[5:0]; pulseTick();
      check("R4 date sweep", alarmFlag, d == 17);
    end
    curDate = 6'h17;
    for (int w = 1; w <= 7; w++) begin
      clearFlag(); curDow = 6'(w); pulseTick();
      check("R4 dow ignored", alarmFlag, 1'b1);
    end

    // R5: day mode (bit 6 set, day 5)
    wr(3'd4, 8'h45);
    for (int w = 1; w <= 7; w++) begin
      clearFlag(); curDow = 6'(w); pulseTick();
      check("R5 dow sweep", alarmFlag, w == 5);
    end
    curDow = 6'd5;
    for (int d = 1; d <= 31; d++) begin
      clearFlag(); curDate = toBcd(d)[5:0]; pulseTick();
      check("R5 date ignored", alarmFlag, 1'b1);
    end

    // R8: sticky until clear
    curSec = 8'h59;
    repeat (3) pulseTick();
    check("R8 sticky", alarmFlag, 1'b1);
    @(negedge clk); afClr = 1'b1; tick = 1'b1;
    @(negedge clk); afClr = 1'b0; tick = 1'b0;
    check("R8 clear with mismatch tick", alarmFlag, 1'b0);

    // R9: match and clear in the same cycle
    curSec = 8'h12; pulseTick();
    @(negedge clk); afClr = 1'b1; tick = 1'b1;
    @(negedge clk); afClr = 1'b0; tick = 1'b0;
    check("R9 match beats clear", alarmFlag, 1'b1);

    // R10: interrupt gating, flag set
    for (int m = 0; m < 4; m++) begin
      wr(3'd5, 8'(m));
      check("R10 intN flag set", intN, !(m == 3));
    end
    clearFlag();
    check("R10 intN flag clear", intN, 1'b1);

    // R11: unused selects leave alarm registers intact
    wr(3'd6, 8'h00); wr(3'd7, 8'h00);
    check("R11 ctrl kept", intN, 1'b1);
    pulseTick();
    check("R11 alarm kept", alarmFlag, 1'b1);
    check("R11 int still enabled", intN, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule